// File: doc/BRIEF.md
# Compact Timestamp Seconds Extender

Hardware that stamps events often keeps only a 32-bit compact word per event. The low 30 bits hold the nanoseconds of the event and the top two bits hold the two lowest bits of its seconds count. This block turns that compact word back into a full 48-bit seconds value plus 30-bit nanoseconds. It does this by comparing the event's two seconds bits against a reference seconds value that the surrounding system captures from the full clock about every two seconds.

The block forms the difference between the event bits and the low two bits of the reference, modulo 4. It reads that difference as a signed step in the window −1 to +2 seconds and adds the step to the reference. Compact words enter through a valid/ready handshake, and rebuilt stamps leave through another valid/ready handshake in the same order. A separate strobe loads a new reference. Until the first reference arrives after reset, every output carries a flag that marks it as built without a reference.

Top module: `ts_sec_extender`

## Requirements
- R1: Output nanoseconds equal bits 29:0 of the accepted compact word.
- R2: Bits 1:0 of the output seconds always equal bits 31:30 of the accepted compact word.
- R3: When (word bits 31:30 − reference bits 1:0) mod 4 is 0, 1 or 2, the output seconds equal the reference plus that value.
- R4: When that modulo-4 difference is 3, the output seconds equal the reference minus 1.
- R5: A reference presented with `ref_load` high replaces the old one after that clock edge. A compact word accepted on the same edge still uses the old reference, and every later word uses the new one.
- R6: `out_noref` is 1 for outputs whose word was accepted before any `ref_load` since reset, and 0 afterwards. Without a reference, the reference value is taken as 0.
- R7: Exactly one output is produced per accepted word, in acceptance order. While `out_valid` is high and `out_ready` is low, the output and its fields hold steady and `in_ready` is low.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: Seconds arithmetic wraps modulo 2^48. Reference 2^48−1 with a +1 step gives 0, and reference 0 with a −1 step gives 2^48−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_load | input | 1 | Strobe that loads a new reference seconds value |
| ref_sec | input | 48 | Reference seconds, sampled when `ref_load` is high |
| in_valid | input | 1 | Compact word present |
| in_ready | output | 1 | Block can take a compact word |
| in_stamp | input | 32 | Compact word: [31:30] low seconds bits, [29:0] nanoseconds |
| out_valid | output | 1 | Rebuilt stamp present |
| out_ready | input | 1 | Consumer takes the rebuilt stamp |
| out_sec | output | 48 | Rebuilt full seconds |
| out_ns | output | 30 | Nanoseconds of the event |
| out_noref | output | 1 | Stamp was built before any reference was loaded |

## Verification
The rebuild is exercised with all four modulo-4 differences against references whose low bits are 00, 01 and 11. This separates a correct modulo difference from a plain subtraction, and the −1 reading from a +3 reading. References at the top and bottom of the 48-bit range show whether the add wraps. Loading a reference in the same cycle as an input tells apart "new reference applies next" from "applies at once". A stalled consumer with a second word waiting shows whether data holds steady and order is kept.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

  // Width of the seconds bits carried in a compact word; fixes the -1..+2 window.
  localparam int unsigned TSX_LO_W = 2;

  // Signed step from reference to event seconds, read from the two low bits.
  function automatic logic signed [2:0] tsx_step(input logic [TSX_LO_W-1:0] evt_lo,
                                                 input logic [TSX_LO_W-1:0] ref_lo);
    logic [TSX_LO_W-1:0] diff;
    diff = evt_lo - ref_lo;
    if (diff == 2'b11) return -3'sd1;
    return signed'({1'b0, diff});
  endfunction

endpackage

// File: rtl/tsx_ref_hold.sv
module tsx_ref_hold #(
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  output logic [SEC_W-1:0] ref_sec_q,
  output logic             ref_seen
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sec_q <= '0;
      ref_seen  <= 1'b0;
    end else if (load) begin
      ref_sec_q <= load_sec;
      ref_seen  <= 1'b1;
    end
  end

endmodule

// File: rtl/tsx_sec_rebuild.sv
module tsx_sec_rebuild
  import tsx_pkg::*;
#(
  parameter int unsigned SEC_W = 48
) (
  input  logic [SEC_W-1:0]    ref_sec,
  input  logic [TSX_LO_W-1:0] evt_lo,
  output logic signed [2:0]   step,
  output logic [SEC_W-1:0]    sec_full
);

  localparam int unsigned EXT_W = SEC_W - 3;

  always_comb begin
    step     = tsx_step(evt_lo, ref_sec[TSX_LO_W-1:0]);
    sec_full = ref_sec + {{EXT_W{step[2]}}, step};
  end

endmodule

// File: rtl/tsx_out_reg.sv
module tsx_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);

  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

endmodule

// File: rtl/ts_sec_extender.sv
module ts_sec_extender
  import tsx_pkg::*;
#(
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_load,
  input  logic [SEC_W-1:0]           ref_sec,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NS_W+TSX_LO_W-1:0]   in_stamp,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SEC_W-1:0]           out_sec,
  output logic [NS_W-1:0]            out_ns,
  output logic                       out_noref
);

  localparam int unsigned PAY_W = 1 + SEC_W + NS_W;

  logic [SEC_W-1:0]    ref_sec_q;
  logic                ref_seen;
  logic signed [2:0]   sec_step;
  logic [SEC_W-1:0]    sec_full;
  logic [PAY_W-1:0]    pay_in;
  logic [PAY_W-1:0]    pay_out;
  logic                accept;

  tsx_ref_hold #(.SEC_W(SEC_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ref_load),
    .load_sec  (ref_sec),
    .ref_sec_q (ref_sec_q),
    .ref_seen  (ref_seen)
  );

  tsx_sec_rebuild #(.SEC_W(SEC_W)) u_rebuild (
    .ref_sec  (ref_sec_q),
    .evt_lo   (in_stamp[NS_W +: TSX_LO_W]),
    .step     (sec_step),
    .sec_full (sec_full)
  );

  assign pay_in = {!ref_seen, sec_full, in_stamp[NS_W-1:0]};
  assign accept = in_valid && in_ready;

  tsx_out_reg #(.DATA_W(PAY_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign {out_noref, out_sec, out_ns} = pay_out;

endmodule

// File: rtl/tsx_checker.sv
module tsx_checker #(
  parameter int unsigned SEC_W = 48,
  parameter int unsigned NS_W  = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_load,
  input logic               accept,
  input logic [NS_W+1:0]    in_stamp,
  input logic [SEC_W-1:0]   ref_sec_q,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SEC_W-1:0]   out_sec,
  input logic [NS_W-1:0]    out_ns,
  input logic               out_noref
);

  logic             seen_load;
  logic [SEC_W-1:0] ref_snap;
  logic [SEC_W-1:0] sec_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_load <= 1'b0;
      ref_snap  <= '0;
    end else begin
      if (ref_load) seen_load <= 1'b1;
      if (accept)   ref_snap  <= ref_sec_q;
    end
  end

  assign sec_gap = out_sec - ref_snap;

  assert_ns_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_ns == $past(in_stamp[NS_W-1:0]));

  assert_low_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_sec[1:0] == $past(in_stamp[NS_W+1:NS_W]));

  // R3 and R4: step from the reference stays within -1..+2 (R9 wrap included)
  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sec_gap <= SEC_W'(2)) || (sec_gap == {SEC_W{1'b1}}));

  assert_noref_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !seen_load) |=> out_noref);

  assert_noref_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seen_load) |=> !out_noref);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sec) && $stable(out_ns)
                                  && $stable(out_noref));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_reset_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

endmodule

bind ts_sec_extender tsx_checker #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_load  (ref_load),
  .accept    (accept),
  .in_stamp  (in_stamp),
  .ref_sec_q (ref_sec_q),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sec   (out_sec),
  .out_ns    (out_ns),
  .out_noref (out_noref)
);

// File: tb/sim_ts_sec_extender.sv
module sim_ts_sec_extender;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [47:0] V_REF [NV] = '{
    48'd100, 48'd100, 48'd100, 48'd100, 48'd7, 48'd7, 48'd7,
    48'hFFFF_FFFF_FFFF, 48'd0, 48'h1234_5678_9ABD};
  localparam logic [1:0] V_LO [NV] = '{
    2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd1, 2'd0, 2'd3, 2'd1};
  localparam logic [29:0] V_NS [NV] = '{
    30'd0, 30'd1, 30'd999_999_999, 30'd12345, 30'h3FFF_FFFF,
    30'd77, 30'd500_000_000, 30'd3, 30'd4, 30'h2AAA_AAAA};
  localparam logic [47:0] V_EXP [NV] = '{
    48'd100, 48'd101, 48'd102, 48'd99, 48'd8, 48'd6, 48'd9,
    48'd0, 48'hFFFF_FFFF_FFFF, 48'h1234_5678_9ABD};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_load = 1'b0;
  logic [47:0] ref_sec = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_stamp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [47:0] out_sec;
  logic [29:0] out_ns;
  logic        out_noref;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_sec_extender u0 (
    .clk(clk), .rst_n(rst_n), .ref_load(ref_load), .ref_sec(ref_sec),
    .in_valid(in_valid), .in_ready(in_ready), .in_stamp(in_stamp),
    .out_valid(out_valid), .out_ready(out_ready), .out_sec(out_sec),
    .out_ns(out_ns), .out_noref(out_noref));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic load_ref(input logic [47:0] r);
    @(negedge clk);
    ref_load = 1'b1; ref_sec = r;
    @(negedge clk);
    ref_load = 1'b0;
  endtask

  // Send one word with the consumer ready; result is visible one cycle later.
  task automatic send(input logic [1:0] lo, input logic [29:0] ns);
    @(negedge clk);
    in_valid = 1'b1; in_stamp = {lo, ns};
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: state right after reset
    chk("R8 out_valid", 64'(out_valid), 64'd0);
    chk("R8 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after release", 64'(out_valid), 64'd0);

    // R6: no reference yet, reference taken as 0
    send(2'd2, 30'd5);
    chk("R6 noref flag", 64'(out_noref), 64'd1);
    chk("R6 sec without ref", 64'(out_sec), 64'd2);
    chk("R1 ns without ref", 64'(out_ns), 64'd5);

    // R1 R2 R3 R4 R9: vector table
    for (int i = 0; i < NV; i++) begin
      load_ref(V_REF[i]);
      send(V_LO[i], V_NS[i]);
      chk($sformatf("R3/R4/R9 sec vec%0d", i), 64'(out_sec), 64'(V_EXP[i]));
      chk($sformatf("R2 low bits vec%0d", i), 64'(out_sec[1:0]), 64'(V_LO[i]));
      chk($sformatf("R1 ns vec%0d", i), 64'(out_ns), 64'(V_NS[i]));
      chk($sformatf("R6 flag clear vec%0d", i), 64'(out_noref), 64'd0);
    end

    // R5: load and input on the same edge; old reference 0x1234_5678_9ABD applies
    @(negedge clk);
    ref_load = 1'b1; ref_sec = 48'd1000;
    in_valid = 1'b1; in_stamp = {2'd1, 30'd9};
    @(negedge clk);
    ref_load = 1'b0; in_valid = 1'b0;
    chk("R5 same-edge uses old ref", 64'(out_sec), 64'h1234_5678_9ABD);
    send(2'd1, 30'd10);
    chk("R5 next input uses new ref", 64'(out_sec), 64'd1001);

    // R7: backpressure with a second word waiting
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_stamp = {2'd0, 30'd11};
    @(negedge clk);
    in_stamp = {2'd3, 30'd22};
    for (int k = 0; k < 3; k++) begin
      chk("R7 held valid", 64'(out_valid), 64'd1);
      chk("R7 held sec A", 64'(out_sec), 64'd1000);
      chk("R7 held ns A", 64'(out_ns), 64'd11);
      chk("R7 in_ready low", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 second word sec", 64'(out_sec), 64'd999);
    chk("R7 second word ns", 64'(out_ns), 64'd22);
    chk("R7 second word valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R7 one output per input", 64'(out_valid), 64'd0);

    finish_run();
  end

endmodule